// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is a bank of 32-bit event counters next to one 32-bit cycle counter, all run through a small register port. Each event counter has a type register. The type register picks one line of an event input vector and also says at which privilege levels the counter may count. The cycle counter has no type register. It advances on every clock, or once every 64 clocks when the divide bit is set. A wrap past 0xFFFFFFFF raises a sticky flag, and one shared interrupt line goes high while any flag is set and that counter's interrupt is enabled.

Software reaches the event counters through a select register. The counter-data and type addresses act on whichever event counter the select register names. The enable registers, interrupt-enable registers and overflow flags work as bit masks. Event counter i sits at bit i, and the cycle counter sits at bit 31. The register port is a plain one-cycle control port with no back-pressure. A write is taken on the rising edge when `reg_wr` is high, and `reg_rdata` shows the register at `reg_addr` in the same cycle, combinationally. No stream interface exists, so valid/ready does not apply.

Word addresses: 0x0 control, 0x1 counter-enable set, 0x2 counter-enable clear, 0x3 interrupt-enable set, 0x4 interrupt-enable clear, 0x5 overflow flags, 0x6 software increment, 0x7 select, 0x8 selected counter data, 0x9 selected type, 0xA cycle counter data. All other addresses read as 0. With the defaults, N = 4 event counters are built.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, all counters, enables, flags and the select value are 0 and `irq` is low. Address 0x0 then reads 0x2000, which is N=4 in bits 15:11.
- R2: At address 0x0 only bits 5:0 are stored. Bit 0 is the global count enable and bit 3 is the cycle divide-by-64. Bits 1 and 2 always read back as 0.
- R3: Writing bit 1 of 0x0 clears every event counter, and writing bit 2 clears the cycle counter. Neither one changes the overflow flags.
- R4: Writing 1s to 0x1 or 0x3 sets enable bits, and writing 1s to 0x2 or 0x4 clears them. Zero bits have no effect. Each pair reads back the same enables, and only bits 0..N-1 and 31 exist.
- R5: An event counter advances on a clock edge only when all of these hold: global enable, its enable bit, a privilege level that its filter allows, and its event active. Event number 0x11 is active on every cycle. An event number k from 1 to 31 (k not 0x11) follows `event_in[k]`.
- R6: The type register at 0x9 keeps only the bits in 0xC80003FF. Bit 30 blocks level 0, bit 31 blocks level 1, and level 2 counts only when bit 27 is set. Level 3 is never filtered.
- R7: Address 0x7 selects event counter S, and 0x8 and 0x9 then read and write counter S. When S is N or more, those addresses read 0 and writes to them are ignored.
- R8: The cycle counter at 0xA advances when bit 0 of 0x0 and enable bit 31 are both set. With bit 3 set, it advances only on every 64th enabled clock.
- R9: A wrap from 0xFFFFFFFF to 0 sets flag i (bit 31 for the cycle counter) at 0x5. Writing 1 clears a flag and writing 0 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R10: `irq` is high exactly while some flag at 0x5 is set and its matching bit at 0x3 is set.
- R11: Writing 0x6 with bit i set advances event counter i by one when its event number is 0x00 and the conditions of R5 hold. `event_in[0]` never advances a counter.
- R12: A write to a counter's data register wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| event_in | input | EVT_W (32) | Event lines, one per event number |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The hardest case to reach from the ports is a counter wrap that lands on the same clock edge as a software write clearing that same flag. The stimulus primes the counter to 0xFFFFFFFF with the global enable off. It then turns the global enable on and, in the very next write cycle, sends the clearing write, so the first counting edge and the clear coincide. The divide-by-64 cycle mode is hard to observe, because only every 64th enabled edge shows up. The bench clears the prescaler and the counter in the same write as the enable and then holds counting for exactly 128 edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_EN_SET = 4'h1;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 4'h2;
  localparam logic [ADDR_W-1:0] A_IE_SET = 4'h3;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 4'h4;
  localparam logic [ADDR_W-1:0] A_OVF    = 4'h5;
  localparam logic [ADDR_W-1:0] A_SWINC  = 4'h6;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'h7;
  localparam logic [ADDR_W-1:0] A_EVCNT  = 4'h8;
  localparam logic [ADDR_W-1:0] A_EVTYPE = 4'h9;
  localparam logic [ADDR_W-1:0] A_CYCCNT = 4'hA;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_CLRE  = 1;
  localparam int CB_CLRC  = 2;
  localparam int CB_DIV   = 3;
  localparam logic [5:0] CTRL_KEEP = 6'b111001;

  // type register layout
  localparam logic [DATA_W-1:0] TYPE_KEEP = 32'hC800_03FF;
  localparam int TB_NO_L1 = 31;
  localparam int TB_NO_L0 = 30;
  localparam int TB_ON_L2 = 27;
  localparam int EVNUM_W  = 10;
  localparam logic [EVNUM_W-1:0] EV_SOFT  = 10'h000;
  localparam logic [EVNUM_W-1:0] EV_CLOCK = 10'h011;

  localparam int CYC_BIT = 31;
  localparam int PRESC_W = 6;
  localparam int SEL_W   = 5;
endpackage

// File: rtl/pmu_priv_filter.sv
module pmu_priv_filter (
  input  logic [1:0] priv_lvl,
  input  logic       no_l0,
  input  logic       no_l1,
  input  logic       on_l2,
  output logic       allow
);
  always_comb begin
    unique case (priv_lvl)
      2'd0:    allow = !no_l0;
      2'd1:    allow = !no_l1;
      2'd2:    allow = on_l2;
      default: allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
#(
  parameter int EVT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,        // global and per-counter enable
  input  logic [1:0]        priv_lvl,
  input  logic [EVT_W-1:0]  event_in,
  input  logic              soft_inc,
  input  logic              clear_all,
  input  logic              wr_count,
  input  logic              wr_type,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] type_q,
  output logic              wrap
);
  localparam int IDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic [EVNUM_W-1:0] evnum;
  logic               hw_hit;
  logic               sw_hit;
  logic               allow;
  logic               bump;

  assign evnum = type_q[EVNUM_W-1:0];

  pmu_priv_filter u_filter (
    .priv_lvl (priv_lvl),
    .no_l0    (type_q[TB_NO_L0]),
    .no_l1    (type_q[TB_NO_L1]),
    .on_l2    (type_q[TB_ON_L2]),
    .allow    (allow)
  );

  always_comb begin
    if (evnum == EV_CLOCK)
      hw_hit = 1'b1;
    else if (evnum != EV_SOFT && int'(evnum) < EVT_W)
      hw_hit = event_in[evnum[IDX_W-1:0]];
    else
      hw_hit = 1'b0;
  end

  assign sw_hit = (evnum == EV_SOFT) && soft_inc;
  assign bump   = run && allow && (hw_hit || sw_hit);
  assign wrap   = bump && !clear_all && !wr_count && (&count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_q <= '0;
    else if (clear_all)  count_q <= '0;
    else if (wr_count)   count_q <= wdata;
    else if (bump)       count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       type_q <= '0;
    else if (wr_type) type_q <= wdata & TYPE_KEEP;
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              div64,
  input  logic              clear,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_q,
  output logic              wrap
);
  logic [PRESC_W-1:0] presc_q;
  logic               tick;

  assign tick = run && (!div64 || (&presc_q));
  assign wrap = tick && !clear && !wr_count && (&count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     presc_q <= '0;
    else if (clear) presc_q <= '0;
    else if (run)   presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (clear)    count_q <= '0;
    else if (wr_count) count_q <= wdata;
    else if (tick)     count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int EVT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  event_in,
  input  logic [1:0]        priv_lvl,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));
  localparam logic [4:0] NUM_FIELD = 5'(NUM_CNT);

  logic [5:0]        ctrl_q;
  logic [DATA_W-1:0] cnten_q, inten_q, ovf_q;
  logic [SEL_W-1:0]  sel_q;
  logic              ctrl_en, sel_ok;
  logic              wr_ctrl, clr_evt, clr_cyc;

  logic [DATA_W-1:0] evt_count [NUM_CNT];
  logic [DATA_W-1:0] evt_type  [NUM_CNT];
  logic [NUM_CNT-1:0] evt_wrap;
  logic [DATA_W-1:0] cyc_count;
  logic              cyc_wrap;
  logic [DATA_W-1:0] wrap_vec;
  logic [DATA_W-1:0] sel_count, sel_type;

  assign ctrl_en = ctrl_q[CB_EN];
  assign sel_ok  = int'(sel_q) < NUM_CNT;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign clr_evt = wr_ctrl && reg_wdata[CB_CLRE];
  assign clr_cyc = wr_ctrl && reg_wdata[CB_CLRC];

  // control and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnten_q <= '0;
      inten_q <= '0;
      sel_q   <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        A_CTRL:   ctrl_q  <= reg_wdata[5:0] & CTRL_KEEP;
        A_EN_SET: cnten_q <= cnten_q | (reg_wdata & IMPL_MASK);
        A_EN_CLR: cnten_q <= cnten_q & ~reg_wdata;
        A_IE_SET: inten_q <= inten_q | (reg_wdata & IMPL_MASK);
        A_IE_CLR: inten_q <= inten_q & ~reg_wdata;
        A_SEL:    sel_q   <= reg_wdata[SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  // overflow flags: a new wrap beats a same-cycle clear
  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_CNT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT]     = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else if (reg_wr && reg_addr == A_OVF)
      ovf_q <= (ovf_q & ~reg_wdata) | wrap_vec;
    else
      ovf_q <= ovf_q | wrap_vec;
  end

  assign irq = |(ovf_q & inten_q);

  // event counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit_sel;
    assign hit_sel = sel_ok && sel_q == SEL_W'(i);

    pmu_event_counter #(.EVT_W(EVT_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ctrl_en && cnten_q[i]),
      .priv_lvl  (priv_lvl),
      .event_in  (event_in),
      .soft_inc  (reg_wr && reg_addr == A_SWINC && reg_wdata[i]),
      .clear_all (clr_evt),
      .wr_count  (reg_wr && reg_addr == A_EVCNT && hit_sel),
      .wr_type   (reg_wr && reg_addr == A_EVTYPE && hit_sel),
      .wdata     (reg_wdata),
      .count_q   (evt_count[i]),
      .type_q    (evt_type[i]),
      .wrap      (evt_wrap[i])
    );
  end

  pmu_cycle_counter u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_en && cnten_q[CYC_BIT]),
    .div64    (ctrl_q[CB_DIV]),
    .clear    (clr_cyc),
    .wr_count (reg_wr && reg_addr == A_CYCCNT),
    .wdata    (reg_wdata),
    .count_q  (cyc_count),
    .wrap     (cyc_wrap)
  );

  // selected-counter read window
  always_comb begin
    sel_count = '0;
    sel_type  = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_count = evt_count[i];
        sel_type  = evt_type[i];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = {16'b0, NUM_FIELD, 5'b0, ctrl_q};
      A_EN_SET, A_EN_CLR: reg_rdata = cnten_q;
      A_IE_SET, A_IE_CLR: reg_rdata = inten_q;
      A_OVF:    reg_rdata = ovf_q;
      A_SEL:    reg_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      A_EVCNT:  reg_rdata = sel_count;
      A_EVTYPE: reg_rdata = sel_type;
      A_CYCCNT: reg_rdata = cyc_count;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnten_q,
  input logic [DATA_W-1:0] ovf_q,
  input logic              ctrl_en,
  input logic [DATA_W-1:0] cyc_count,
  input logic              cyc_wrap
);
  localparam logic [DATA_W-1:0] IMPL =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));

  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_CTRL |-> (reg_rdata[2:1] == 2'b00 && reg_rdata[15:11] == 5'(NUM_CNT)));

  p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN_SET) |=>
      ((cnten_q & $past(reg_wdata & IMPL)) == $past(reg_wdata & IMPL)));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN_CLR) |=> ((cnten_q & $past(reg_wdata)) == '0));

  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !(reg_wr && (reg_addr == A_CYCCNT || reg_addr == A_CTRL))) |=> $stable(cyc_count));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_q[CYC_BIT]);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OVF && reg_wdata[CYC_BIT] && !cyc_wrap) |=> !ovf_q[CYC_BIT]);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0));
endmodule

bind perf_counter_unit pmu_checker #(.NUM_CNT(NUM_CNT)) u_pmu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .cnten_q   (cnten_q),
  .ovf_q     (ovf_q),
  .ctrl_en   (ctrl_en),
  .cyc_count (cyc_count),
  .cyc_wrap  (cyc_wrap)
);

// File: tb/test_perf_counter_unit.sv
module test_perf_counter_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NROWS = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] event_in = '0;
  logic [1:0]  priv_lvl = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_unit i_perf_counter_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
    .priv_lvl(priv_lvl), .irq(irq)
  );

  // row: write?, write addr, write data, read addr, expected read
  localparam logic [72:0] ROWS [NROWS] = '{
    {1'b1, 4'h1, 32'hFFFF_FFFF, 4'h1, 32'h8000_000F},
    {1'b1, 4'h2, 32'h0000_0005, 4'h2, 32'h8000_000A},
    {1'b1, 4'h1, 32'h0000_0000, 4'h1, 32'h8000_000A},
    {1'b1, 4'h2, 32'hFFFF_FFFF, 4'h1, 32'h0000_0000},
    {1'b1, 4'h3, 32'h8000_0003, 4'h4, 32'h8000_0003},
    {1'b1, 4'h4, 32'h8000_0000, 4'h3, 32'h0000_0003},
    {1'b1, 4'h7, 32'h0000_0002, 4'h7, 32'h0000_0002},
    {1'b1, 4'h9, 32'hFFFF_FFFF, 4'h9, 32'hC800_03FF},
    {1'b1, 4'h7, 32'h0000_0001, 4'h9, 32'h0000_0000},
    {1'b1, 4'h8, 32'h0000_1234, 4'h8, 32'h0000_1234},
    {1'b1, 4'h7, 32'h0000_0002, 4'h8, 32'h0000_0000},
    {1'b1, 4'h7, 32'h0000_0007, 4'h8, 32'h0000_0000},
    {1'b1, 4'h9, 32'h0000_0011, 4'h9, 32'h0000_0000},
    {1'b1, 4'h7, 32'h0000_0001, 4'h8, 32'h0000_1234},
    {1'b1, 4'h0, 32'hFFFF_FFFF, 4'h0, 32'h0000_2039},
    {1'b1, 4'h7, 32'h0000_0001, 4'h8, 32'h0000_0000},
    {1'b1, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_2000}
  };

  function automatic string row_tag(int i);
    if (i < 6) return "R4";
    if (i == 7) return "R6";
    if (i == 14 || i == 16) return "R2";
    if (i == 15) return "R3";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  // global enable on, n idle edges, global enable off: n+1 counting edges
  task automatic run_en(int n);
    wr(4'h0, 32'h1);
    repeat (n) @(negedge clk);
    wr(4'h0, 32'h0);
  endtask

  task automatic filt_case(logic [31:0] t, logic [1:0] p, logic [31:0] exp);
    wr(4'h8, 32'h0);
    wr(4'h9, t);
    priv_lvl = p;
    run_en(4);
    rd_chk("R6 filter", 4'h8, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 4'h0, 32'h2000);
    rd_chk("R1 enables", 4'h1, 32'h0);
    rd_chk("R1 irq enables", 4'h3, 32'h0);
    rd_chk("R1 flags", 4'h5, 32'h0);
    rd_chk("R1 select", 4'h7, 32'h0);
    rd_chk("R1 counter", 4'h8, 32'h0);
    rd_chk("R1 cycles", 4'hA, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [72:0] r;
      r = ROWS[i];
      if (r[72]) wr(r[71:68], r[67:36]);
      rd_chk(row_tag(i), r[35:32], r[31:0]);
    end

    // R5 clock-cycle event on counter 0
    priv_lvl = 2'd0;
    wr(4'h7, 32'h0);
    wr(4'h9, 32'h11);
    wr(4'h1, 32'h1);
    run_en(10);
    rd_chk("R5 cycles event", 4'h8, 32'd11);
    repeat (5) @(negedge clk);
    rd_chk("R5 global off holds", 4'h8, 32'd11);
    wr(4'h2, 32'h1);
    run_en(4);
    rd_chk("R5 enable bit off holds", 4'h8, 32'd11);

    // R6 privilege filtering
    wr(4'h1, 32'h1);
    filt_case(32'h4000_0011, 2'd0, 32'd0);
    filt_case(32'h4000_0011, 2'd1, 32'd5);
    filt_case(32'h8000_0011, 2'd1, 32'd0);
    filt_case(32'h0000_0011, 2'd2, 32'd0);
    filt_case(32'h0800_0011, 2'd2, 32'd5);
    filt_case(32'hC000_0011, 2'd3, 32'd5);
    priv_lvl = 2'd0;

    // R5 event line 5 on counter 1
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h2);
    wr(4'h7, 32'h1);
    wr(4'h9, 32'h5);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h1);
    event_in = 32'h60;
    repeat (3) @(negedge clk);
    event_in = 32'h0;
    wr(4'h0, 32'h0);
    rd_chk("R5 event line", 4'h8, 32'd3);

    // R8 cycle counter
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h8000_0000);
    wr(4'hA, 32'h0);
    run_en(9);
    rd_chk("R8 every clock", 4'hA, 32'd10);
    wr(4'h0, 32'hD);
    repeat (127) @(negedge clk);
    wr(4'h0, 32'h0);
    rd_chk("R8 divide by 64", 4'hA, 32'd2);

    // R9 / R10 overflow on counter 2
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h4);
    wr(4'h3, 32'h4);
    wr(4'h7, 32'h2);
    wr(4'h9, 32'h11);
    wr(4'h8, 32'hFFFF_FFFE);
    run_en(1);
    rd_chk("R9 wrapped value", 4'h8, 32'h0);
    rd_chk("R9 flag set", 4'h5, 32'h4);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    wr(4'h5, 32'h0);
    rd_chk("R9 zero write keeps", 4'h5, 32'h4);
    wr(4'h5, 32'h4);
    rd_chk("R9 w1c", 4'h5, 32'h0);
    check("R10 irq dropped", {31'b0, irq}, 32'h0);

    wr(4'h4, 32'h4);
    wr(4'h8, 32'hFFFF_FFFF);
    run_en(0);
    rd_chk("R9 flag again", 4'h5, 32'h4);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h3, 32'h4);
    check("R10 irq on enable", {31'b0, irq}, 32'h1);
    wr(4'h5, 32'h4);

    // R9 wrap and clear on the same edge
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h0, 32'h1);
    wr(4'h5, 32'h4);
    wr(4'h0, 32'h0);
    rd_chk("R9 set beats clear", 4'h5, 32'h4);
    wr(4'h5, 32'h4);

    // R9 cycle counter wrap, then R3 clears
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h8000_0000);
    wr(4'hA, 32'hFFFF_FFFF);
    run_en(0);
    rd_chk("R9 cycle flag", 4'h5, 32'h8000_0000);
    wr(4'hA, 32'h55);
    wr(4'h0, 32'h6);
    rd_chk("R3 cycle cleared", 4'hA, 32'h0);
    rd_chk("R3 event cleared", 4'h8, 32'h0);
    rd_chk("R3 flags kept", 4'h5, 32'h8000_0000);
    wr(4'h5, 32'hFFFF_FFFF);

    // R11 software increment on counter 3
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h8);
    wr(4'h7, 32'h3);
    wr(4'h9, 32'h0);
    wr(4'h8, 32'h0);
    event_in = 32'hFFFF_FFFF;
    wr(4'h0, 32'h1);
    wr(4'h6, 32'h8);
    wr(4'h6, 32'h7);
    wr(4'h6, 32'h8);
    wr(4'h6, 32'h8);
    wr(4'h0, 32'h0);
    event_in = 32'h0;
    rd_chk("R11 soft increments", 4'h8, 32'd3);
    wr(4'h6, 32'h8);
    rd_chk("R11 global off", 4'h8, 32'd3);

    // R12 write beats increment
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h1);
    wr(4'h7, 32'h0);
    wr(4'h9, 32'h11);
    wr(4'h8, 32'h50);
    wr(4'h0, 32'h1);
    wr(4'h8, 32'h100);
    wr(4'h0, 32'h0);
    rd_chk("R12 write priority", 4'h8, 32'h101);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule